// File: doc/BRIEF.md
# Partial-Word Edge Store Unit

This block prepares the first or last word of an unaligned block copy for a big-endian memory port. A request carries a 32-bit register value, a byte address, a select between the leading-edge (begin) and trailing-edge (end) variant, and a valid strobe. One cycle later the block presents a word-aligned write with a byte-enable mask, the write data already placed in its byte lanes, and a flag saying that the write is only a probe.

The begin variant writes from the addressed byte through the last byte of the word. The end variant writes from the first byte of the word up to the addressed byte, which it leaves untouched. When the end variant sees a word-aligned address it writes no byte at all. It still issues a zero-length probe, so that the memory side checks write permission and marks the line dirty. Every request, including the three-byte cases, leaves as exactly one masked beat, so a partial word never reaches memory in two pieces.

Top module: `edge_store_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `wr_valid`, `wr_be` and `wr_probe` are all zero.
- R2: Each cycle with `req_valid` high produces exactly one cycle with `wr_valid` high on the next cycle. No beat appears without a request.
- R3: `wr_addr` equals `req_addr` with bits [1:0] cleared.
- R4: Begin mode (`req_end`=0) with offset k=`req_addr[1:0]` enables byte lanes k..3. Lane 0 is the most significant byte, and `wr_be[3-j]` enables lane j. This gives `wr_be` = 1111, 0111, 0011, 0001 for k = 0, 1, 2, 3.
- R5: End mode (`req_end`=1) with offset k enables byte lanes 0..k-1. This gives `wr_be` = 0000, 1000, 1100, 1110 for k = 0, 1, 2, 3.
- R6: Each enabled byte of `wr_data[8b+7:8b]` carries `req_value[8b+7:8b]`, with no shift. Begin mode therefore writes the low bytes of the value and end mode writes the high bytes. Disabled bytes are zero.
- R7: `wr_probe` is high exactly for end mode with offset 0, and then `wr_be` is zero.
- R8: The three-byte cases (begin offset 1 and end offset 3) are carried in a single beat with all three lanes enabled together.
- R9: When `wr_valid` is low, `wr_be` and `wr_probe` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_end | input | 1 | 0 selects the begin variant, 1 the end variant |
| req_addr | input | ADDR_W | Byte address of the edge |
| req_value | input | DATA_W | Register value to store |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | ADDR_W | Word-aligned write address |
| wr_be | output | DATA_W/8 | Byte enables, bit 3 is the lowest-addressed byte |
| wr_data | output | DATA_W | Lane-aligned write data |
| wr_probe | output | 1 | Zero-length write probe |

## Verification
All eight combinations of variant and address offset are driven. Each is driven with values whose four bytes are all distinct, so a shifted or misplaced lane shows up as a wrong byte and not as a lucky match. Requests are issued back to back and also with idle gaps, which separates a beat that was lost or duplicated from one that is merely late. The aligned end case is checked for both an empty mask and a raised probe. The two three-byte cases are checked for their full mask in a single beat. High address bits vary between requests, which exposes faults in the address path that clearing only the low bits would hide.

// File: rtl/esu_pkg.sv
// Shared types for the edge store unit.
// Assumes: nothing beyond standard SystemVerilog.
package esu_pkg;
    typedef enum logic {
        EDGE_BEGIN = 1'b0,
        EDGE_END   = 1'b1
    } edge_mode_e;
endpackage

// File: rtl/esu_lane_decode.sv
// Combinational lane decoder. It works out the byte-enable mask, the lane
// data and the probe flag from the edge variant and the byte offset.
// Assumes: big-endian lanes, so lane 0 is the most significant byte and
// maps to be[BYTES-1].
module esu_lane_decode
    import esu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  edge_mode_e         mode,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  value,
    output logic [BYTES-1:0]   be,
    output logic [DATA_W-1:0]  data,
    output logic               probe
);
    // One lane slice per byte: enable by edge variant, data unshifted.
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        localparam int BIT = BYTES - 1 - i;
        logic en;
        assign en = (mode == EDGE_END) ? (OFF_W'(i) < off) : (OFF_W'(i) >= off);
        assign be[BIT] = en;
        assign data[BIT*8 +: 8] = en ? value[BIT*8 +: 8] : 8'h00;
    end

    // The aligned end case writes nothing, but still asks for a probe.
    assign probe = (mode == EDGE_END) && (off == '0);
endmodule

// File: rtl/esu_out_stage.sv
// Output register stage. It holds one write beat per accepted request.
// Assumes: synchronous active-low reset. The enables and the probe are
// cleared on idle cycles, while address and data keep their last value.
module esu_out_stage #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BYTES-1:0]  in_be,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_probe,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BYTES-1:0]  out_be,
    output logic [DATA_W-1:0] out_data,
    output logic              out_probe
);
    // Control flops: valid, enables and probe, cleared on reset and idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_be    <= '0;
            out_probe <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_be    <= in_valid ? in_be : '0;
            out_probe <= in_valid && in_probe;
        end
    end

    // Payload flops: address and data are loaded only with a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_data <= '0;
        end else if (in_valid) begin
            out_addr <= in_addr;
            out_data <= in_data;
        end
    end
endmodule

// File: rtl/edge_store_unit.sv
// Top of the edge store unit. It turns a begin or end partial-word store
// request into a single word-aligned, byte-masked write beat one cycle later.
// Assumes: one request per cycle at most and no back-pressure from memory.
module edge_store_unit
    import esu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_end,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_value,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTES-1:0]  wr_be,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_probe
);
    edge_mode_e         mode;
    logic [OFF_W-1:0]   off;
    logic [ADDR_W-1:0]  word_addr;
    logic [BYTES-1:0]   dec_be;
    logic [DATA_W-1:0]  dec_data;
    logic               dec_probe;

    // Split the address into the offset inside the word and the word base.
    assign mode      = edge_mode_e'(req_end);
    assign off       = req_addr[OFF_W-1:0];
    assign word_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    esu_lane_decode #(.DATA_W(DATA_W)) u_dec (
        .mode  (mode),
        .off   (off),
        .value (req_value),
        .be    (dec_be),
        .data  (dec_data),
        .probe (dec_probe)
    );

    esu_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_addr   (word_addr),
        .in_be     (dec_be),
        .in_data   (dec_data),
        .in_probe  (dec_probe),
        .out_valid (wr_valid),
        .out_addr  (wr_addr),
        .out_be    (wr_be),
        .out_data  (wr_data),
        .out_probe (wr_probe)
    );

    // R2: a request yields a beat on the next cycle.
    assert_beat_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> wr_valid);
    // R2: no beat appears without a request.
    assert_no_spurious_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !wr_valid);
    // R3: every beat is word aligned.
    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[OFF_W-1:0] == '0));
    // R4: a begin request always writes the last byte of the word.
    assert_begin_last_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_end) |=> wr_be[0]);
    // R5: an end request never writes the last byte of the word.
    assert_end_no_last_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_end) |=> !wr_be[0]);
    // R7: a probe carries an empty mask.
    assert_probe_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_probe |-> (wr_valid && wr_be == '0));
    // R9: idle cycles carry no enables and no probe.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (wr_be == '0 && !wr_probe));
endmodule

// File: tb/edge_store_unit_tb_top.sv
module edge_store_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic        probe;
        logic        endm;
        logic [1:0]  off;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_end = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_value = '0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic        wr_probe;

    int n_checks = 0;
    int n_fails  = 0;
    bit mon_on   = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_store_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_end(req_end),
        .req_addr(req_addr), .req_value(req_value), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .wr_probe(wr_probe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one request per call, the expected beat is pushed to the queue.
    task automatic send(input bit endm, input logic [31:0] addr, input logic [31:0] val);
        exp_t e;
        logic [1:0] k;
        k = addr[1:0];
        e.addr  = {addr[31:2], 2'b00};
        e.be    = endm ? (~(4'b1111 >> k) & 4'hF) : (4'b1111 >> k);
        e.data  = '0;
        for (int b = 0; b < 4; b++)
            if (e.be[b]) e.data[b*8 +: 8] = val[b*8 +: 8];
        e.probe = endm && (k == 2'd0);
        e.endm  = endm;
        e.off   = k;
        @(negedge clk);
        req_valid = 1'b1;
        req_end   = endm;
        req_addr  = addr;
        req_value = val;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compare each beat with the oldest expected item.
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected beat", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(wr_addr == e.addr, "R3 address", wr_addr, e.addr);
                    if (e.endm)
                        check(wr_be == e.be, "R5 end mask", {28'd0, wr_be}, {28'd0, e.be});
                    else
                        check(wr_be == e.be, "R4 begin mask", {28'd0, wr_be}, {28'd0, e.be});
                    check(wr_data == e.data, "R6 lane data", wr_data, e.data);
                    check(wr_probe == e.probe, "R7 probe", {31'd0, wr_probe}, {31'd0, e.probe});
                    if ((!e.endm && e.off == 2'd1) || (e.endm && e.off == 2'd3))
                        check($countones(wr_be) == 3, "R8 three-byte single beat",
                              {28'd0, wr_be}, {28'd0, e.be});
                end
            end else begin
                check(wr_be == 4'd0 && !wr_probe, "R9 idle quiet",
                      {27'd0, wr_probe, wr_be}, 32'd0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!wr_valid && wr_be == 4'd0 && !wr_probe, "R1 in reset",
              {27'd0, wr_valid, wr_be}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_valid && wr_be == 4'd0 && !wr_probe, "R1 after reset",
              {27'd0, wr_valid, wr_be}, 32'd0);
        mon_on = 1'b1;

        // R4 R5: all eight variant/offset combinations, back to back.
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < 4; k++)
                send(m[0], 32'h1000_0040 + 32'(k) + 32'(m*16), 32'hA1B2_C3D4);
        idle(3);

        // R6 R8: distinct bytes, high address bits varied, with idle gaps.
        send(1'b0, 32'hFFFF_FFF1, 32'h0102_0304);
        idle(2);
        send(1'b1, 32'h8000_0003, 32'hCAFE_F00D);
        idle(1);
        // R7: aligned end case writes nothing but probes.
        send(1'b1, 32'h0000_0100, 32'hDEAD_BEEF);
        send(1'b1, 32'h7654_3210, 32'h1122_3344);
        send(1'b0, 32'h7654_3210, 32'h5566_7788);
        idle(2);

        for (int r = 0; r < 16; r++)
            send(r[0], 32'(r * 32'h0137_0A05), 32'h9E37_79B9 * 32'(r + 1));
        idle(4);

        // R2: every request produced exactly one beat.
        check(sb.size() == 0, "R2 all beats delivered", 32'(sb.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule